// File: doc/BRIEF.md
# Framed Synchronous Serial Packet Transmitter

The block takes 32-bit words from an internal word FIFO and sends them one byte at a time as framed characters on a single data line. An external send-timing reference gives one `bit_tick` strobe per bit period. Each character is a start bit, eight data bits, a parity bit and a gap of marking bits. The start and marking levels, odd or even parity, the bit order within a byte and the byte order within a word can all be set.

Packet length, in bytes, comes from one of two places. In queued mode each packet pops its own length from a small length FIFO. In fixed mode one length register applies to every packet, and packets go out back to back until the word FIFO runs dry. A packet starts only when the transmitter is enabled, clear-to-send is high, a word is waiting and a length is available.

The block keeps two latched status bits, underflow and packet-done, which are cleared by writing a one. It also has an almost-empty flag. Each of the three conditions has its own interrupt enable.

The state machine has these states:

- **ST_IDLE**: the line rests at the marking level. On a tick, when the enable, clear-to-send, a stored word and an available length are all present, it loads a word and goes to ST_START. In queued mode a zero length is popped and the state stays ST_IDLE.
- **ST_START**: drives the start level. The next tick goes to ST_DATA.
- **ST_DATA**: sends eight data bits, one per tick. After the eighth bit it goes to ST_PARITY.
- **ST_PARITY**: drives the parity bit. The next tick goes to ST_STOP.
- **ST_STOP**: drives MARK_BITS marking bits. After the last one it does one of three things:
  - goes to ST_START with the next byte of the same word, or with a freshly popped word;
  - goes to ST_IDLE when the packet is complete, setting packet-done;
  - goes to ST_IDLE when a new word is needed and none is stored, setting underflow.
- **Abort**: whenever the enable is low, the state is forced to ST_IDLE on the next clock.

Top module: `txf_top`

## Requirements
- R1: After reset `sdata` sits at `mark_level`. `busy`, `underflow_sts`, `done_sts` and `word_count` are all 0.
- R2: Each character is one bit at `start_level`, then 8 data bits, one parity bit, and MARK_BITS (default 2) bits at `mark_level`. Each bit lasts one tick period. Between packets the line stays at `mark_level`.
- R3: The parity bit makes the count of ones in the data and parity bits odd when `odd_parity`=1, and even when `odd_parity`=0.
- R4: With `lsb_first`=1, data bit 0 is sent first; otherwise bit 7 is sent first. With `byte_swap`=0 a word sends bits [7:0] first and [31:24] last; with `byte_swap`=1 the order is reversed.
- R5: No character starts while `tx_enable`=0, while `cts`=0, while the word FIFO is empty, or, in queued mode, while the length FIFO is empty. Clear-to-send is examined only when a packet starts.
- R6: In queued mode (`len_from_reg`=0) each packet pops one length and sends exactly that many bytes. Every packet starts with a freshly popped word, and any unsent bytes of a packet's last word are discarded.
- R7: In fixed mode (`len_from_reg`=1) packets of `fixed_len` bytes are sent back to back until the word FIFO is empty.
- R8: In queued mode a zero length is popped and dropped. No character is sent and no word is consumed.
- R9: When a packet needs a new word and the FIFO is empty, the packet is abandoned and `underflow_sts` is set. A pulse on `clear_w1c[0]` clears it. `irq` is high while it is set and `uf_irq_en`=1.
- R10: `done_sts` is set when the last marking bit of a packet's last character ends. A pulse on `clear_w1c[1]` clears it. `irq` is high while it is set and `done_irq_en`=1.
- R11: `almost_empty` is 1 exactly when `word_count` < `ae_level`. `irq` is high while it is 1 and `ae_irq_en`=1.
- R12: Dropping `tx_enable` abandons any character in flight. By the next clock the line is at `mark_level` and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit period, from the send-timing reference |
| cts | input | 1 | Clear-to-send |
| tx_enable | input | 1 | Transmitter run enable |
| len_from_reg | input | 1 | 1: fixed length register, 0: length FIFO |
| fixed_len | input | LEN_W (16) | Bytes per packet in fixed mode |
| start_level | input | 1 | Level of the start bit |
| mark_level | input | 1 | Level of marking and idle bits |
| odd_parity | input | 1 | 1: odd parity, 0: even parity |
| lsb_first | input | 1 | Bit order within a byte |
| byte_swap | input | 1 | Byte order within a word |
| ae_level | input | CNT_W (5) | Almost-empty threshold |
| uf_irq_en | input | 1 | Underflow interrupt enable |
| ae_irq_en | input | 1 | Almost-empty interrupt enable |
| done_irq_en | input | 1 | Packet-done interrupt enable |
| word_wr | input | 1 | Write strobe for the word FIFO |
| word_data | input | 32 | Word to store |
| word_full | output | 1 | Word FIFO full |
| len_wr | input | 1 | Write strobe for the length FIFO |
| len_data | input | LEN_W (16) | Packet length to queue |
| len_full | output | 1 | Length FIFO full |
| clear_w1c | input | 2 | Status clear pulse: bit 0 underflow, bit 1 done |
| sdata | output | 1 | Serial data line |
| busy | output | 1 | State machine not in ST_IDLE |
| word_count | output | CNT_W (5) | Words held in the word FIFO |
| almost_empty | output | 1 | Word count below threshold |
| underflow_sts | output | 1 | Latched underflow |
| done_sts | output | 1 | Latched packet done |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults show up on `sdata` within one character time, about twelve tick periods.

- A wrong bit counter or a misplaced state change shows as a bad stop bit, a shifted byte or a parity mismatch in the character being sent.
- A wrong byte index or byte counter shows as a wrong byte, or as a packet whose length is off.
- A bad packet-boundary decision shows at the end of the packet: a stray extra character, a missing character, or a wrong `done_sts` or `underflow_sts` value.
- FIFO pointer or count errors appear at once on `word_count` and `almost_empty`.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } txf_state_e;

    // Select byte number idx of a word; swap reverses the byte order.
    function automatic logic [7:0] pick_byte(input logic [31:0] w,
                                             input logic [1:0]  idx,
                                             input logic        swap);
        logic [1:0] sel;
        sel = swap ? (2'd3 - idx) : idx;
        unique case (sel)
            2'd0: return w[7:0];
            2'd1: return w[15:8];
            2'd2: return w[23:16];
            default: return w[31:24];
        endcase
    endfunction

endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             push_ok, pop_ok;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + 1'b1;
            if (pop_ok)  rp_q <= rp_q + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R9
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/txf_frame_fsm.sv
module txf_frame_fsm
    import txf_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MARK_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             cts,
    input  logic             tx_enable,
    input  logic             len_from_reg,
    input  logic [LEN_W-1:0] fixed_len,
    input  logic [LEN_W-1:0] len_head,
    input  logic             len_empty,
    input  logic [31:0]      word_head,
    input  logic             word_empty,
    input  logic             start_level,
    input  logic             mark_level,
    input  logic             odd_parity,
    input  logic             lsb_first,
    input  logic             byte_swap,
    output logic             word_pop,
    output logic             len_pop,
    output logic             uf_pulse,
    output logic             done_pulse,
    output logic             sdata,
    output logic             busy
);
    localparam int BC_W = $clog2((MARK_BITS > 8) ? MARK_BITS : 8) + 1;
    localparam logic [BC_W-1:0] LAST_DATA = BC_W'(7);
    localparam logic [BC_W-1:0] LAST_MARK = BC_W'(MARK_BITS - 1);

    txf_state_e       state_q, state_d;
    logic [BC_W-1:0]  bit_q, bit_d;
    logic [31:0]      word_q, word_d;
    logic [1:0]       idx_q, idx_d;
    logic [7:0]       byte_q, byte_d;
    logic [LEN_W-1:0] left_q, left_d;

    logic             len_avail;
    logic [LEN_W-1:0] cur_len;
    logic             go;

    assign len_avail = len_from_reg ? (fixed_len != '0) : !len_empty;
    assign cur_len   = len_from_reg ? fixed_len : len_head;
    assign go        = cts && !word_empty && len_avail;

    // Next-state and datapath decisions
    always_comb begin
        state_d    = state_q;
        bit_d      = bit_q;
        word_d     = word_q;
        idx_d      = idx_q;
        byte_d     = byte_q;
        left_d     = left_q;
        word_pop   = 1'b0;
        len_pop    = 1'b0;
        uf_pulse   = 1'b0;
        done_pulse = 1'b0;
        if (!tx_enable) begin
            state_d = ST_IDLE;
        end else if (bit_tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        if (!len_from_reg && (len_head == '0)) begin
                            len_pop = 1'b1;
                        end else begin
                            word_pop = 1'b1;
                            len_pop  = !len_from_reg;
                            word_d   = word_head;
                            idx_d    = 2'd0;
                            byte_d   = pick_byte(word_head, 2'd0, byte_swap);
                            left_d   = cur_len;
                            state_d  = ST_START;
                        end
                    end
                end
                ST_START: begin
                    bit_d   = '0;
                    state_d = ST_DATA;
                end
                ST_DATA: begin
                    if (bit_q == LAST_DATA) begin
                        state_d = ST_PARITY;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
                ST_PARITY: begin
                    bit_d   = '0;
                    state_d = ST_STOP;
                end
                ST_STOP: begin
                    if (bit_q != LAST_MARK) begin
                        bit_d = bit_q + 1'b1;
                    end else if (left_q == LEN_W'(1)) begin
                        done_pulse = 1'b1;
                        state_d    = ST_IDLE;
                    end else if (idx_q != 2'd3) begin
                        idx_d   = idx_q + 2'd1;
                        byte_d  = pick_byte(word_q, idx_q + 2'd1, byte_swap);
                        left_d  = left_q - 1'b1;
                        state_d = ST_START;
                    end else if (!word_empty) begin
                        word_pop = 1'b1;
                        word_d   = word_head;
                        idx_d    = 2'd0;
                        byte_d   = pick_byte(word_head, 2'd0, byte_swap);
                        left_d   = left_q - 1'b1;
                        state_d  = ST_START;
                    end else begin
                        uf_pulse = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            word_q  <= '0;
            idx_q   <= '0;
            byte_q  <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            word_q  <= word_d;
            idx_q   <= idx_d;
            byte_q  <= byte_d;
            left_q  <= left_d;
        end
    end

    // Line outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START:  sdata = start_level;
            ST_DATA:   sdata = lsb_first ? byte_q[bit_q[2:0]] : byte_q[3'd7 - bit_q[2:0]];
            ST_PARITY: sdata = (^byte_q) ^ odd_parity;
            default:   sdata = mark_level;
        endcase
    end

    // R5
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) == ST_IDLE) |-> $past(cts && tx_enable && !word_empty));

    // R12
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (state_q == ST_IDLE));

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_enable) && (state_q != $past(state_q))) |-> $past(bit_tick));

endmodule

// File: rtl/txf_status.sv
module txf_status #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uf_set,
    input  logic          done_set,
    input  logic [1:0]    clear_w1c,
    input  logic [CW-1:0] word_count,
    input  logic [CW-1:0] ae_level,
    input  logic          uf_irq_en,
    input  logic          ae_irq_en,
    input  logic          done_irq_en,
    output logic          underflow_sts,
    output logic          done_sts,
    output logic          almost_empty,
    output logic          irq
);
    logic uf_q, done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (uf_set)            uf_q <= 1'b1;
            else if (clear_w1c[0]) uf_q <= 1'b0;
            if (done_set)          done_q <= 1'b1;
            else if (clear_w1c[1]) done_q <= 1'b0;
        end
    end

    assign underflow_sts = uf_q;
    assign done_sts      = done_q;
    assign almost_empty  = (word_count < ae_level);
    assign irq           = (uf_q && uf_irq_en) || (done_q && done_irq_en) ||
                           (almost_empty && ae_irq_en);

    // R9
    uf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_set |=> uf_q);

    // R10
    done_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> done_q);

endmodule

// File: rtl/txf_top.sv
module txf_top #(
    parameter int WORD_DEPTH = 16,
    parameter int LEN_DEPTH  = 4,
    parameter int LEN_W      = 16,
    parameter int MARK_BITS  = 2,
    parameter int CNT_W      = $clog2(WORD_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             cts,
    input  logic             tx_enable,
    input  logic             len_from_reg,
    input  logic [LEN_W-1:0] fixed_len,
    input  logic             start_level,
    input  logic             mark_level,
    input  logic             odd_parity,
    input  logic             lsb_first,
    input  logic             byte_swap,
    input  logic [CNT_W-1:0] ae_level,
    input  logic             uf_irq_en,
    input  logic             ae_irq_en,
    input  logic             done_irq_en,
    input  logic             word_wr,
    input  logic [31:0]      word_data,
    output logic             word_full,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_data,
    output logic             len_full,
    input  logic [1:0]       clear_w1c,
    output logic             sdata,
    output logic             busy,
    output logic [CNT_W-1:0] word_count,
    output logic             almost_empty,
    output logic             underflow_sts,
    output logic             done_sts,
    output logic             irq
);
    localparam int LCW = $clog2(LEN_DEPTH) + 1;

    logic [31:0]      word_head;
    logic             word_empty, word_pop;
    logic [LEN_W-1:0] len_head;
    logic             len_empty, len_pop;
    logic [LCW-1:0]   len_count;
    logic             uf_pulse, done_pulse;

    txf_fifo #(.WIDTH(32), .DEPTH(WORD_DEPTH), .CW(CNT_W)) u_words (
        .clk(clk), .rst_n(rst_n), .push(word_wr), .din(word_data),
        .pop(word_pop), .dout(word_head), .empty(word_empty),
        .full(word_full), .count(word_count)
    );

    txf_fifo #(.WIDTH(LEN_W), .DEPTH(LEN_DEPTH), .CW(LCW)) u_lens (
        .clk(clk), .rst_n(rst_n), .push(len_wr), .din(len_data),
        .pop(len_pop), .dout(len_head), .empty(len_empty),
        .full(len_full), .count(len_count)
    );

    txf_frame_fsm #(.LEN_W(LEN_W), .MARK_BITS(MARK_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cts(cts),
        .tx_enable(tx_enable), .len_from_reg(len_from_reg),
        .fixed_len(fixed_len), .len_head(len_head), .len_empty(len_empty),
        .word_head(word_head), .word_empty(word_empty),
        .start_level(start_level), .mark_level(mark_level),
        .odd_parity(odd_parity), .lsb_first(lsb_first), .byte_swap(byte_swap),
        .word_pop(word_pop), .len_pop(len_pop), .uf_pulse(uf_pulse),
        .done_pulse(done_pulse), .sdata(sdata), .busy(busy)
    );

    txf_status #(.CW(CNT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .uf_set(uf_pulse), .done_set(done_pulse),
        .clear_w1c(clear_w1c), .word_count(word_count), .ae_level(ae_level),
        .uf_irq_en(uf_irq_en), .ae_irq_en(ae_irq_en), .done_irq_en(done_irq_en),
        .underflow_sts(underflow_sts), .done_sts(done_sts),
        .almost_empty(almost_empty), .irq(irq)
    );

    // R6
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_count <= LCW'(LEN_DEPTH));

endmodule

// File: tb/sim_txf_top.sv
`timescale 1ns/1ps
module sim_txf_top;
    localparam int MB       = 2;
    localparam int TICK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick;
    logic        cts = 1'b0, tx_enable = 1'b0, len_from_reg = 1'b0;
    logic [15:0] fixed_len = '0;
    logic        start_lv = 1'b1, mark_lv = 1'b0, odd_par = 1'b0;
    logic        lsb_f = 1'b1, bswap = 1'b0;
    logic [4:0]  ae_level = 5'd1;
    logic        uf_irq_en = 1'b0, ae_irq_en = 1'b0, done_irq_en = 1'b0;
    logic        word_wr = 1'b0;
    logic [31:0] word_data = '0;
    logic        len_wr = 1'b0;
    logic [15:0] len_data = '0;
    logic [1:0]  clear_w1c = '0;
    logic        word_full, len_full, sdata, busy, almost_empty;
    logic        underflow_sts, done_sts, irq;
    logic [4:0]  word_count;

    int n_chk = 0, n_fail = 0, cyc = 0, phase = 0, rx_cnt = 0;
    int rx_pos = -1;
    logic [7:0] rx_byte;
    logic       rx_abort = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;
    assign bit_tick = (phase == 0);

    txf_top u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cts(cts),
        .tx_enable(tx_enable), .len_from_reg(len_from_reg), .fixed_len(fixed_len),
        .start_level(start_lv), .mark_level(mark_lv), .odd_parity(odd_par),
        .lsb_first(lsb_f), .byte_swap(bswap), .ae_level(ae_level),
        .uf_irq_en(uf_irq_en), .ae_irq_en(ae_irq_en), .done_irq_en(done_irq_en),
        .word_wr(word_wr), .word_data(word_data), .word_full(word_full),
        .len_wr(len_wr), .len_data(len_data), .len_full(len_full),
        .clear_w1c(clear_w1c), .sdata(sdata), .busy(busy),
        .word_count(word_count), .almost_empty(almost_empty),
        .underflow_sts(underflow_sts), .done_sts(done_sts), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [7:0] byte_of(input logic [31:0] w, input int i);
        int s;
        s = bswap ? 3 - i : i;
        return w[8*s +: 8];
    endfunction

    // Tick generator
    always @(negedge clk) phase <= (phase == TICK_DIV - 1) ? 0 : phase + 1;

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Line receiver model, sampling mid-bit
    always @(negedge clk) begin
        if (rx_abort) begin
            rx_pos = -1;
        end else if (phase == 2) begin
            if (rx_pos < 0) begin
                if (sdata != mark_lv) begin
                    chk(sdata == start_lv, "R2 start level", sdata, start_lv);
                    rx_pos = 1;
                end
            end else if (rx_pos <= 8) begin
                if (lsb_f) rx_byte[rx_pos-1] = sdata;
                else       rx_byte[8-rx_pos] = sdata;
                rx_pos++;
            end else if (rx_pos == 9) begin
                chk(sdata == ((^rx_byte) ^ odd_par), "R3 parity", sdata, (^rx_byte) ^ odd_par);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected character", rx_byte, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_byte == e, "R4 R6 byte value", rx_byte, e);
                end
                rx_cnt++;
                rx_pos++;
            end else begin
                chk(sdata == mark_lv, "R2 marking bit", sdata, mark_lv);
                if (rx_pos == 9 + MB) rx_pos = -1;
                else rx_pos++;
            end
        end
    end

    task automatic put_word(input logic [31:0] w);
        @(negedge clk); word_wr = 1'b1; word_data = w;
        @(negedge clk); word_wr = 1'b0;
    endtask

    task automatic put_len(input int n);
        @(negedge clk); len_wr = 1'b1; len_data = 16'(n);
        @(negedge clk); len_wr = 1'b0;
    endtask

    task automatic send_pkt(input int len);
        logic [31:0] w [4];
        int nw;
        nw = (len + 3) / 4;
        for (int i = 0; i < nw; i++) begin w[i] = $urandom; put_word(w[i]); end
        for (int k = 0; k < len; k++) exp_q.push_back(byte_of(w[k/4], k % 4));
        put_len(len);
    endtask

    task automatic wait_idle();
        int quiet;
        quiet = 0;
        while (quiet < 24) begin
            @(negedge clk);
            if (busy) quiet = 0; else quiet++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clear(input logic [1:0] m);
        @(negedge clk); clear_w1c = m;
        @(negedge clk); clear_w1c = 2'b00;
    endtask

    task automatic do_reset();
        tx_enable = 1'b0;
        rst_n = 1'b0;
        rx_abort = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rx_abort = 1'b0;
        exp_q.delete();
        @(negedge clk);
    endtask

    task automatic rand_cfg();
        mark_lv  = 1'($urandom % 2);
        start_lv = ~mark_lv;
        odd_par  = 1'($urandom % 2);
        lsb_f    = 1'($urandom % 2);
        bswap    = 1'($urandom % 2);
    endtask

    initial begin
        void'($urandom(32'd1357));
        do_reset();

        // R1 reset state
        chk(sdata == mark_lv, "R1 line idle", sdata, mark_lv);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(underflow_sts == 1'b0 && done_sts == 1'b0, "R1 status", {underflow_sts, done_sts}, 0);
        chk(word_count == 0, "R1 word count", word_count, 0);

        // R5 gating: enable low, then cts low, then no length
        cts = 1'b1;
        for (int i = 0; i < 4; i++) put_word($urandom);
        repeat (120) @(negedge clk);
        chk(busy == 1'b0 && rx_cnt == 0, "R5 enable low", rx_cnt, 0);
        tx_enable = 1'b1;
        repeat (120) @(negedge clk);
        chk(busy == 1'b0 && word_count == 4, "R5 no length queued", word_count, 4);
        do_reset();
        cts = 1'b0;
        send_pkt(4);
        tx_enable = 1'b1;
        repeat (120) @(negedge clk);
        chk(rx_cnt == 0 && word_count == 1, "R5 cts low", rx_cnt, 0);
        cts = 1'b1;
        wait_idle();
        chk(rx_cnt == 4 && exp_q.size() == 0, "R5 cts released", rx_cnt, 4);
        chk(done_sts == 1'b1, "R10 done set", done_sts, 1);
        done_irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R10 done irq", irq, 1);
        pulse_clear(2'b10);
        chk(done_sts == 1'b0 && irq == 1'b0, "R10 done cleared", done_sts, 0);
        done_irq_en = 1'b0;

        // R6 queued mode, random configurations
        for (int b = 0; b < 6; b++) begin
            int np;
            tx_enable = 1'b0;
            rand_cfg();
            rx_cnt = 0;
            np = 1 + int'($urandom % 4);
            for (int p = 0; p < np; p++) begin
                int nw;
                nw = 1 + int'($urandom % 3);
                send_pkt(4 * (nw - 1) + 1 + int'($urandom % 4));
            end
            tx_enable = 1'b1;
            wait_idle();
            chk(exp_q.size() == 0, "R6 all bytes sent", exp_q.size(), 0);
            chk(word_count == 0, "R6 words consumed", word_count, 0);
            chk(underflow_sts == 1'b0, "R6 no underflow", underflow_sts, 0);
            pulse_clear(2'b10);
        end

        // R8 zero length dropped
        tx_enable = 1'b0;
        rx_cnt = 0;
        put_len(0);
        send_pkt(4);
        tx_enable = 1'b1;
        wait_idle();
        chk(rx_cnt == 4 && exp_q.size() == 0, "R8 zero length", rx_cnt, 4);
        chk(word_count == 0, "R8 word count", word_count, 0);

        // R7 fixed mode, back to back
        for (int f = 0; f < 2; f++) begin
            int fl, wpp, nw;
            logic [31:0] w;
            tx_enable = 1'b0;
            rand_cfg();
            rx_cnt = 0;
            len_from_reg = 1'b1;
            fl = (f == 0) ? 8 : 3;
            fixed_len = 16'(fl);
            wpp = (fl + 3) / 4;
            nw = (f == 0) ? 4 : 3;
            for (int p = 0; p < nw / wpp; p++) begin
                logic [31:0] ws [2];
                for (int i = 0; i < wpp; i++) begin w = $urandom; ws[i] = w; put_word(w); end
                for (int k = 0; k < fl; k++) exp_q.push_back(byte_of(ws[k/4], k % 4));
            end
            tx_enable = 1'b1;
            wait_idle();
            chk(rx_cnt == fl * (nw / wpp), "R7 fixed packets", rx_cnt, fl * (nw / wpp));
            chk(exp_q.size() == 0 && underflow_sts == 1'b0, "R7 clean end", exp_q.size(), 0);
        end
        len_from_reg = 1'b0;
        pulse_clear(2'b11);

        // R9 underflow: length 9 with only 2 words
        tx_enable = 1'b0;
        rx_cnt = 0;
        uf_irq_en = 1'b1;
        begin
            logic [31:0] a, c;
            a = $urandom; c = $urandom;
            put_word(a); put_word(c);
            for (int k = 0; k < 8; k++) exp_q.push_back(byte_of(k < 4 ? a : c, k % 4));
            put_len(9);
        end
        tx_enable = 1'b1;
        wait_idle();
        chk(rx_cnt == 8, "R9 bytes before underflow", rx_cnt, 8);
        chk(underflow_sts == 1'b1, "R9 underflow latched", underflow_sts, 1);
        chk(done_sts == 1'b0, "R9 no done", done_sts, 0);
        chk(irq == 1'b1, "R9 irq", irq, 1);
        pulse_clear(2'b01);
        chk(underflow_sts == 1'b0 && irq == 1'b0, "R9 cleared", underflow_sts, 0);
        uf_irq_en = 1'b0;

        // R11 almost-empty threshold
        do_reset();
        for (int n = 0; n < 6; n++) begin
            for (int lv = 0; lv < 8; lv++) begin
                ae_level = 5'(lv);
                @(negedge clk);
                chk(almost_empty == (n < lv), "R11 almost empty", almost_empty, n < lv);
            end
            put_word($urandom);
        end
        ae_level = 5'd10;
        ae_irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R11 irq", irq, 1);
        ae_irq_en = 1'b0;
        ae_level = 5'd1;

        // R12 abort mid-packet
        do_reset();
        send_pkt(12);
        tx_enable = 1'b1;
        repeat (100) @(negedge clk);
        rx_abort = 1'b1;
        tx_enable = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R12 busy", busy, 0);
        chk(sdata == mark_lv, "R12 line marking", sdata, mark_lv);
        do_reset();

        finish_run();
    end
endmodule